// File: doc/BRIEF.md
# Indirect Indexed Register Window with Pin Control

This block lets an 8-bit register bus reach a 16-bit internal register space through just two bus offsets. One offset is an index port and the other is a data port. A host selects an internal location in three writes. It first writes a key byte to the index port. The next data-port write then loads the upper address byte. A plain index-port write loads the lower address byte. After that, data-port writes store into the selected location and data-port reads return its contents. The location stays selected until the host changes it.

The internal space holds two registers. A configuration register enables software control of an output pin. A level register supplies that pin's level. A host typically selects the level register, reads it, changes bit 0, and writes the byte back. The pin can be driven straight from the registers or through one extra flop, chosen by a parameter.

Top module: `ixp_window_port`

## Requirements
- R1: After reset the selected address is 0x0000, the window is not armed, both internal registers hold 0x00, `gpio_pin` is low and `bus_rdata` is 0x00.
- R2: Writing the key 0x9F to the index port (offset 0xF4) arms the window. The next write to the data port (offset 0xF5) loads bits [15:8] of the selected address, stores nothing, and disarms the window.
- R3: A write of any value other than the key to the index port loads bits [7:0] of the selected address. Because of this, 0x9F can never be a low address byte.
- R4: A data-port write while the window is not armed stores all 8 bits at the selected location. The configuration register is at 0x104F and the level register is at 0xFE3F.
- R5: While `bus_rd` is high with offset 0xF5, `bus_rdata` shows the selected location in the same cycle. For every other offset, and whenever `bus_rd` is low, `bus_rdata` is 0x00.
- R6: A read of an unmapped internal address returns 0x00. A write to an unmapped internal address changes neither register.
- R7: `gpio_pin` equals bit 0 of the level register only while bits [3:0] of the configuration register equal 4'b0001. Otherwise it is low. With PIN_STAGE=0 the pin follows the cycle after the write. With PIN_STAGE=1 it follows one cycle later.
- R8: A non-key index write clears the armed state, and so does reset. A data write that follows either one stores to the target instead of loading the upper byte.
- R9: The selected address persists across accesses. Repeated reads and read-modify-write updates of one location need no new selection, and bits that were not changed are kept.
- R10: Writes to bus offsets other than 0xF4 and 0xF5 have no effect on the address, the armed state or the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| gpio_pin | output | 1 | Software-controlled output pin |

## Verification
The bench builds two copies side by side with default offsets, key and register addresses. They differ only in PIN_STAGE: one uses 0 and the other uses 1. Both copies are driven by the same stimulus, so the direct and the flopped pin paths are checked against one behavioural model on every clock. Comparing the two also exposes any one-cycle skew between them. The default key value lets the bench exercise the key colliding with a low address byte, and the default register addresses give distinct upper bytes (0x10, 0xFE) for the high-byte load to tell apart.

// File: rtl/ixp_pkg.sv
package ixp_pkg;
   typedef enum logic {
      WIN_IDLE  = 1'b0,
      WIN_ARMED = 1'b1
   } win_state_e;

   typedef struct packed {
      logic idx_wr;
      logic dat_wr;
      logic dat_rd;
   } bus_dec_t;
endpackage

// File: rtl/ixp_decode.sv
module ixp_decode
   import ixp_pkg::*;
#(
   parameter int               BUS_AW   = 8,
   parameter logic [BUS_AW-1:0] IDX_PORT = 8'hF4,
   parameter logic [BUS_AW-1:0] DAT_PORT = 8'hF5
) (
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output bus_dec_t          dec
);
   always_comb begin
      dec.idx_wr = bus_wr && (bus_addr == IDX_PORT);
      dec.dat_wr = bus_wr && (bus_addr == DAT_PORT);
      dec.dat_rd = bus_rd && (bus_addr == DAT_PORT);
   end
endmodule

// File: rtl/ixp_pointer.sv
module ixp_pointer
   import ixp_pkg::*;
#(
   parameter int            DW  = 8,
   parameter logic [DW-1:0] KEY = 8'h9F,
   localparam int           TAW = 2 * DW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  bus_dec_t       dec,
   input  logic [DW-1:0]  wdata,
   output logic           armed,
   output logic [TAW-1:0] sel_addr,
   output logic           tgt_wr
);
   win_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= WIN_IDLE;
         sel_addr <= '0;
      end else if (dec.idx_wr) begin
         if (wdata == KEY) begin
            state_q <= WIN_ARMED;
         end else begin
            state_q           <= WIN_IDLE;
            sel_addr[DW-1:0]  <= wdata;
         end
      end else if (dec.dat_wr && state_q == WIN_ARMED) begin
         sel_addr[TAW-1:DW] <= wdata;
         state_q            <= WIN_IDLE;
      end
   end

   assign armed  = (state_q == WIN_ARMED);
   assign tgt_wr = dec.dat_wr && (state_q == WIN_IDLE);
endmodule

// File: rtl/ixp_gpio_bank.sv
module ixp_gpio_bank #(
   parameter int             DW        = 8,
   parameter int             EN_W      = 4,
   parameter logic [2*DW-1:0] CFG_ADDR = 16'h104F,
   parameter logic [2*DW-1:0] VAL_ADDR = 16'hFE3F,
   parameter logic [EN_W-1:0] EN_CODE  = 4'b0001,
   parameter bit             PIN_STAGE = 1'b0,
   localparam int            TAW       = 2 * DW,
   localparam int            NREG      = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tgt_wr,
   input  logic [TAW-1:0] sel_addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rd_data,
   output logic [DW-1:0]  cfg_q,
   output logic [DW-1:0]  val_q,
   output logic           pin
);
   localparam logic [NREG*TAW-1:0] ADDR_TAB = {VAL_ADDR, CFG_ADDR};

   logic [DW-1:0]   regs_q [NREG];
   logic [NREG-1:0] hit;

   for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      assign hit[gi] = (sel_addr == ADDR_TAB[gi*TAW +: TAW]);
      always_ff @(posedge clk) begin
         if (!rst_n)               regs_q[gi] <= '0;
         else if (tgt_wr && hit[gi]) regs_q[gi] <= wdata;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) rd_data = rd_data | regs_q[i];
      end
   end

   assign cfg_q = regs_q[0];
   assign val_q = regs_q[1];

   logic pin_src;
   assign pin_src = (regs_q[0][EN_W-1:0] == EN_CODE) && regs_q[1][0];

   if (PIN_STAGE) begin : g_pin_flop
      logic pin_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= pin_src;
      end
      assign pin = pin_q;
   end else begin : g_pin_direct
      assign pin = pin_src;
   end
endmodule

// File: rtl/ixp_window_port.sv
module ixp_window_port
   import ixp_pkg::*;
#(
   parameter int                BUS_AW    = 8,
   parameter int                DW        = 8,
   parameter int                EN_W      = 4,
   parameter logic [BUS_AW-1:0] IDX_PORT  = 8'hF4,
   parameter logic [BUS_AW-1:0] DAT_PORT  = 8'hF5,
   parameter logic [DW-1:0]     KEY       = 8'h9F,
   parameter logic [2*DW-1:0]   CFG_ADDR  = 16'h104F,
   parameter logic [2*DW-1:0]   VAL_ADDR  = 16'hFE3F,
   parameter logic [EN_W-1:0]   EN_CODE   = 4'b0001,
   parameter bit                PIN_STAGE = 1'b0,
   localparam int               TAW       = 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              gpio_pin
);
   if (IDX_PORT == DAT_PORT) begin : g_bad_ports
      $error("index and data ports must sit at different offsets");
   end
   if (CFG_ADDR == VAL_ADDR) begin : g_bad_map
      $error("internal registers must have distinct addresses");
   end
   if (EN_W > DW) begin : g_bad_en
      $error("enable field wider than a register");
   end

   bus_dec_t       dec;
   logic           armed;
   logic [TAW-1:0] sel_addr;
   logic           tgt_wr;
   logic [DW-1:0]  tgt_rdata;
   logic [DW-1:0]  cfg_q;
   logic [DW-1:0]  val_q;

   ixp_decode #(
      .BUS_AW(BUS_AW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
   ) u_dec (
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .dec(dec)
   );

   ixp_pointer #(.DW(DW), .KEY(KEY)) u_ptr (
      .clk(clk), .rst_n(rst_n), .dec(dec), .wdata(bus_wdata),
      .armed(armed), .sel_addr(sel_addr), .tgt_wr(tgt_wr)
   );

   ixp_gpio_bank #(
      .DW(DW), .EN_W(EN_W), .CFG_ADDR(CFG_ADDR), .VAL_ADDR(VAL_ADDR),
      .EN_CODE(EN_CODE), .PIN_STAGE(PIN_STAGE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .tgt_wr(tgt_wr), .sel_addr(sel_addr),
      .wdata(bus_wdata), .rd_data(tgt_rdata), .cfg_q(cfg_q),
      .val_q(val_q), .pin(gpio_pin)
   );

   assign bus_rdata = dec.dat_rd ? tgt_rdata : '0;
endmodule

// File: rtl/ixp_window_port_chk.sv
module ixp_window_port_chk #(
   parameter int                BUS_AW    = 8,
   parameter int                DW        = 8,
   parameter int                EN_W      = 4,
   parameter logic [BUS_AW-1:0] IDX_PORT  = 8'hF4,
   parameter logic [BUS_AW-1:0] DAT_PORT  = 8'hF5,
   parameter logic [DW-1:0]     KEY       = 8'h9F,
   parameter logic [2*DW-1:0]   CFG_ADDR  = 16'h104F,
   parameter logic [2*DW-1:0]   VAL_ADDR  = 16'hFE3F,
   parameter logic [EN_W-1:0]   EN_CODE   = 4'b0001,
   parameter bit                PIN_STAGE = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BUS_AW-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DW-1:0]     bus_wdata,
   input logic [DW-1:0]     bus_rdata,
   input logic              gpio_pin,
   input logic              armed,
   input logic [2*DW-1:0]   sel_addr,
   input logic [DW-1:0]     cfg_q,
   input logic [DW-1:0]     val_q
);
   a_r1_pin_low_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !gpio_pin && !armed);

   a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == IDX_PORT && bus_wdata == KEY) |=> armed);

   a_r2_high_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DAT_PORT && armed)
      |=> (sel_addr[2*DW-1:DW] == $past(bus_wdata)) && !armed
          && $stable(cfg_q) && $stable(val_q));

   a_r3_low_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == IDX_PORT && bus_wdata != KEY)
      |=> sel_addr[DW-1:0] == $past(bus_wdata));

   a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == IDX_PORT && bus_wdata != KEY) |=> !armed);

   a_r5_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || bus_addr != DAT_PORT) |-> bus_rdata == '0);

   a_r6_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_addr != CFG_ADDR && sel_addr != VAL_ADDR) |-> bus_rdata == '0);

   a_r10_other_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != IDX_PORT && bus_addr != DAT_PORT)
      |=> $stable(sel_addr) && $stable(cfg_q) && $stable(val_q));

   if (PIN_STAGE) begin : g_chk_flop
      a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
         gpio_pin |-> $past(cfg_q[EN_W-1:0] == EN_CODE && val_q[0]));
   end else begin : g_chk_direct
      a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
         gpio_pin |-> (cfg_q[EN_W-1:0] == EN_CODE) && val_q[0]);
   end
endmodule

bind ixp_window_port ixp_window_port_chk #(
   .BUS_AW(BUS_AW), .DW(DW), .EN_W(EN_W), .IDX_PORT(IDX_PORT),
   .DAT_PORT(DAT_PORT), .KEY(KEY), .CFG_ADDR(CFG_ADDR), .VAL_ADDR(VAL_ADDR),
   .EN_CODE(EN_CODE), .PIN_STAGE(PIN_STAGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .gpio_pin(gpio_pin), .armed(armed), .sel_addr(sel_addr),
   .cfg_q(cfg_q), .val_q(val_q)
);

// File: tb/ixp_window_port_test.sv
`timescale 1ns/1ps
module ixp_window_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] rdata_a, rdata_b;
   logic       pin_a, pin_b;

   always #5 clk = ~clk;

   ixp_window_port #(.PIN_STAGE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .gpio_pin(pin_a)
   );
   ixp_window_port #(.PIN_STAGE(1'b1)) uut_flop (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .gpio_pin(pin_b)
   );

   // behavioural model
   int  m_armed, m_addr, m_cfg, m_val, m_pinf;
   int  n_checks = 0, n_fail = 0;
   bit  finished = 0;

   function automatic int pin_of(int cfg, int val);
      return (((cfg & 15) == 1) && ((val & 1) == 1)) ? 1 : 0;
   endfunction

   function automatic int model_read(int a, int r);
      if (r == 0 || a != 8'hF5) return 0;
      if (m_addr == 16'h104F) return m_cfg;
      if (m_addr == 16'hFE3F) return m_val;
      return 0;
   endfunction

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_armed = 0; m_addr = 0; m_cfg = 0; m_val = 0; m_pinf = 0;
   endtask

   task automatic step(int a, bit w, bit r, int d, string tag);
      int pin_old;
      @(negedge clk);
      bus_addr = a[7:0]; bus_wr = w; bus_rd = r; bus_wdata = d[7:0];
      #1;
      check(tag, rdata_a, model_read(a, r));
      check(tag, rdata_b, model_read(a, r));
      @(posedge clk);
      pin_old = pin_of(m_cfg, m_val);
      if (w && a == 8'hF4) begin
         if (d == 8'h9F) m_armed = 1;
         else begin m_armed = 0; m_addr = (m_addr & 16'hFF00) | d; end
      end else if (w && a == 8'hF5) begin
         if (m_armed != 0) begin m_addr = (m_addr & 16'h00FF) | (d << 8); m_armed = 0; end
         else if (m_addr == 16'h104F) m_cfg = d;
         else if (m_addr == 16'hFE3F) m_val = d;
      end
      m_pinf = pin_old;
      #1;
      check("R7 direct pin", pin_a, pin_of(m_cfg, m_val));
      check("R7 flopped pin", pin_b, m_pinf);
   endtask

   task automatic select(int addr16, string tag);
      step(8'hF4, 1, 0, 8'h9F, tag);
      step(8'hF5, 1, 0, (addr16 >> 8) & 255, tag);
      step(8'hF4, 1, 0, addr16 & 255, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; bus_wr = 0; bus_rd = 0;
      @(posedge clk); @(posedge clk);
      model_reset();
      #1;
      check("R1 pin", pin_a, 0);
      check("R1 pin flop", pin_b, 0);
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      model_reset();
      do_reset();
      step(8'hF5, 0, 1, 0, "R1 read after reset");

      // select config register and enable control
      select(16'h104F, "R2 R3 select cfg");
      step(8'hF5, 0, 1, 0, "R5 read cfg");
      step(8'hF5, 1, 0, 8'hA1, "R4 write cfg");
      step(8'hF5, 0, 1, 0, "R4 cfg kept all bits");
      step(8'hF4, 0, 1, 0, "R5 index port reads zero");

      // level register, read-modify-write
      select(16'hFE3F, "R2 R3 select val");
      step(8'hF5, 1, 0, 8'h5A, "R4 write val bit0 low");
      step(8'hF5, 0, 1, 0, "R9 readback");
      step(8'hF5, 1, 0, 8'h5B, "R9 rmw set bit0");
      step(8'hF5, 0, 0, 0, "R7 pin rises");
      step(8'hF5, 0, 1, 0, "R9 other bits kept");

      // disable via config
      select(16'h104F, "R3 reselect cfg");
      step(8'hF5, 1, 0, 8'h23, "R7 wrong code");
      step(8'hF5, 0, 0, 0, "R7 pin low");
      step(8'hF5, 1, 0, 8'h01, "R7 code restored");
      step(8'hF5, 0, 0, 0, "R7 pin high again");

      // unmapped
      select(16'h1234, "R6 select unmapped");
      step(8'hF5, 1, 0, 8'hFF, "R6 write ignored");
      step(8'hF5, 0, 1, 0, "R6 read zero");
      select(16'hFE3F, "R6 reselect val");
      step(8'hF5, 0, 1, 0, "R6 val unchanged");

      // disarm by non-key index write
      step(8'hF4, 1, 0, 8'h9F, "R8 arm");
      step(8'hF4, 1, 0, 8'h3F, "R8 disarm by index write");
      step(8'hF5, 1, 0, 8'h0E, "R8 data write stores");
      step(8'hF5, 0, 1, 0, "R8 stored value");

      // key colliding with low byte
      step(8'hF4, 1, 0, 8'h9F, "R3 key never low byte");
      step(8'hF5, 1, 0, 8'hFE, "R3 loads high byte");
      step(8'hF5, 0, 1, 0, "R3 address unchanged low");

      // other offsets
      step(8'h70, 1, 0, 8'h00, "R10 foreign offset write");
      step(8'h00, 1, 0, 8'h55, "R10 foreign offset write 2");
      step(8'hF5, 0, 1, 0, "R10 state intact");
      step(8'h70, 0, 1, 0, "R5 foreign read zero");

      // reset clears armed
      step(8'hF4, 1, 0, 8'h9F, "R8 arm before reset");
      do_reset();
      step(8'hF5, 1, 0, 8'h77, "R8 write after reset unmapped");
      step(8'hF5, 0, 1, 0, "R8 read after reset");
      select(16'h104F, "R1 cfg cleared");
      step(8'hF5, 0, 1, 0, "R1 cfg zero");

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule